// File: doc/BRIEF.md
# Half-Duplex Transmit Deferral Controller

This block decides when a half-duplex CSMA/CD transmitter may put a frame on the wire. When the upper layer requests a transmission, the controller goes busy at once. It then enforces an inter-frame gap of 96 bit times before it hands the medium to the frame logic.

The gap has two parts. The first part lasts `WATCH_BITS` bit times (60 by default) and watches carrier sense. Any carrier activity in this part throws the gap timer back to zero. The second part lasts `BLIND_BITS` bit times (36 by default) and runs to completion whatever the carrier does. When the gap is over, the grant output stays high until the frame logic reports that the frame is finished or asks for deferral to start again.

Time is measured only in `bit_tick` pulses, so the block runs at any ratio of clock to bit rate. The block carries no data, so it has no valid/ready stream and no back-pressure. Every pin is a plain level or single-cycle pulse, sampled on the rising clock edge.

Top module: `defer_ctrl`

## Requirements
- R1: After reset, `busy` and `tx_grant` are both 0.
- R2: A `tx_req` sampled high while idle sets `busy` to 1 in the next cycle, with `tx_grant` still 0.
- R3: `tx_grant` rises in the cycle after the clock edge that samples the 96th counted `bit_tick` of an uninterrupted gap (`WATCH_BITS` + `BLIND_BITS` ticks), and not one tick earlier.
- R4: `carrier_sense` high in any cycle of the watched part of the gap restarts the gap: a full `WATCH_BITS` + `BLIND_BITS` ticks must follow before the grant.
- R5: `carrier_sense` during the final `BLIND_BITS` ticks has no effect on when the grant rises.
- R6: The gap advances only on cycles with `bit_tick` high; cycles without a tick do not shorten it.
- R7: Once high, `tx_grant` stays high until `tx_done` or `restart_defer` is sampled high, and it is 0 in the next cycle after either one.
- R8: `restart_defer` during a grant returns the block to the start of the gap, with `busy` held at 1; a fresh full gap follows.
- R9: `tx_done` during a grant, with no new request, makes `busy` 0 in the next cycle.
- R10: A `tx_req` that is sampled during a grant, or in the same cycle as `tx_done`, keeps `busy` at 1 and starts a new full gap after `tx_done`. Such a request does not end the current grant.
- R11: `tx_grant` is high only while `busy` is high, and the state register is one-hot.
- R12: `tx_done` and `restart_defer` outside a grant are ignored: an idle block stays idle with both outputs at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time on the medium |
| tx_req | input | 1 | Upper-layer request to send a frame (pulse) |
| carrier_sense | input | 1 | Medium activity reported by the physical layer |
| tx_done | input | 1 | Frame logic reports the frame finished (pulse) |
| restart_defer | input | 1 | Frame logic asks for deferral to start over (pulse) |
| busy | output | 1 | Transmitter is deferring or sending |
| tx_grant | output | 1 | Frame logic may transmit now |

## Verification
A gap counter that is off by one shows up as a grant rising one tick early or late. That error is visible at the very first grant after a request, so the scoreboard compares the rise cycle exactly against the edge of the last expected tick. A restart that fails to clear the counter, or a blind phase that wrongly watches the carrier, shifts the grant by many ticks within the same frame. A wrong or lost pending-request flag shows on `busy` in the cycle right after `tx_done`.

// File: rtl/defer_pkg.sv
package defer_pkg;

  localparam int unsigned ST_N     = 4;
  localparam int unsigned IX_IDLE  = 0;
  localparam int unsigned IX_WATCH = 1;
  localparam int unsigned IX_BLIND = 2;
  localparam int unsigned IX_SEND  = 3;

  typedef logic [ST_N-1:0] dstate_t;

  localparam dstate_t ST_IDLE  = dstate_t'(1) << IX_IDLE;
  localparam dstate_t ST_WATCH = dstate_t'(1) << IX_WATCH;
  localparam dstate_t ST_BLIND = dstate_t'(1) << IX_BLIND;
  localparam dstate_t ST_SEND  = dstate_t'(1) << IX_SEND;

endpackage

// File: rtl/gap_timer.sv
// Counts bit ticks up to a selectable limit; hit pulses on the final tick.
module gap_timer #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_q;

  assign hit = step && !clear && (cnt_q == (limit - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || hit) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/defer_fsm.sv
// One-hot sequencer: idle -> watched gap -> blind gap -> send.
module defer_fsm
  import defer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tx_req,
  input  logic    carrier_sense,
  input  logic    bit_tick,
  input  logic    tx_done,
  input  logic    restart_defer,
  input  logic    gap_hit,
  output logic    tmr_clear,
  output logic    tmr_step,
  output logic    watch_phase,
  output dstate_t state_q,
  output logic    pend_q
);

  dstate_t state_d;
  logic    pend_d;
  logic    in_idle, in_watch, in_blind, in_send;

  assign in_idle  = state_q[IX_IDLE];
  assign in_watch = state_q[IX_WATCH];
  assign in_blind = state_q[IX_BLIND];
  assign in_send  = state_q[IX_SEND];

  // Carrier activity only matters while the gap is being watched.
  assign tmr_clear   = in_idle || in_send || (in_watch && carrier_sense);
  assign tmr_step    = bit_tick && (in_watch || in_blind);
  assign watch_phase = in_watch;

  always_comb begin
    state_d = state_q;
    unique case (1'b1)
      in_idle:  if (tx_req) state_d = ST_WATCH;
      in_watch: if (gap_hit) state_d = ST_BLIND;
      in_blind: if (gap_hit) state_d = ST_SEND;
      in_send: begin
        if (restart_defer) begin
          state_d = ST_WATCH;
        end else if (tx_done) begin
          state_d = (pend_q || tx_req) ? ST_WATCH : ST_IDLE;
        end
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  // A request seen during a grant is held until that frame completes.
  always_comb begin
    pend_d = pend_q;
    if (in_send) begin
      if (tx_done && !restart_defer) begin
        pend_d = 1'b0;
      end else begin
        pend_d = pend_q || tx_req;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

endmodule

// File: rtl/defer_ctrl.sv
module defer_ctrl
  import defer_pkg::*;
#(
  parameter int unsigned WATCH_BITS = 60,
  parameter int unsigned BLIND_BITS = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_req,
  input  logic carrier_sense,
  input  logic tx_done,
  input  logic restart_defer,
  output logic busy,
  output logic tx_grant
);

  localparam int unsigned PART_MAX = (WATCH_BITS > BLIND_BITS) ? WATCH_BITS : BLIND_BITS;
  localparam int unsigned CNT_W    = $clog2(PART_MAX + 1);
  localparam logic [CNT_W-1:0] WATCH_LIM = CNT_W'(WATCH_BITS);
  localparam logic [CNT_W-1:0] BLIND_LIM = CNT_W'(BLIND_BITS);

  dstate_t          fsm_state;
  logic             req_pending;
  logic             tmr_clear, tmr_step, gap_hit, watch_phase;
  logic [CNT_W-1:0] gap_limit;

  assign gap_limit = watch_phase ? WATCH_LIM : BLIND_LIM;

  gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (tmr_clear),
    .step  (tmr_step),
    .limit (gap_limit),
    .hit   (gap_hit)
  );

  defer_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_req        (tx_req),
    .carrier_sense (carrier_sense),
    .bit_tick      (bit_tick),
    .tx_done       (tx_done),
    .restart_defer (restart_defer),
    .gap_hit       (gap_hit),
    .tmr_clear     (tmr_clear),
    .tmr_step      (tmr_step),
    .watch_phase   (watch_phase),
    .state_q       (fsm_state),
    .pend_q        (req_pending)
  );

  assign busy     = !fsm_state[IX_IDLE];
  assign tx_grant = fsm_state[IX_SEND];

endmodule

// File: rtl/defer_ctrl_chk.sv
module defer_ctrl_chk
  import defer_pkg::*;
#(
  parameter int unsigned WATCH_BITS = 60,
  parameter int unsigned BLIND_BITS = 36
) (
  input logic    clk,
  input logic    rst_n,
  input logic    bit_tick,
  input logic    tx_req,
  input logic    carrier_sense,
  input logic    tx_done,
  input logic    restart_defer,
  input logic    busy,
  input logic    tx_grant,
  input dstate_t state,
  input logic    pend
);

  localparam int unsigned GAP_TOTAL = WATCH_BITS + BLIND_BITS;

  // Ticks since the gap last began or was restarted by carrier in the watched part.
  logic [15:0] gap_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_ticks <= '0;
    end else if (!busy || tx_grant || (state[IX_WATCH] && carrier_sense)) begin
      gap_ticks <= '0;
    end else if (bit_tick && gap_ticks != 16'hFFFF) begin
      gap_ticks <= gap_ticks + 1'b1;
    end
  end

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && tx_req |=> busy && !tx_grant);

  // Covers R4 and R5 as well: only watched-phase carrier resets the window.
  p_gap_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> gap_ticks == GAP_TOTAL);

  p_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> $past(bit_tick));

  p_grant_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && !tx_done && !restart_defer |=> tx_grant);

  p_grant_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && (tx_done || restart_defer) |=> !tx_grant);

  p_restart_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && restart_defer |=> busy);

  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && tx_done && !restart_defer && !tx_req && !pend |=> !busy);

  p_requeue_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant && tx_done && (tx_req || pend) |=> busy && !tx_grant);

  p_grant_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> busy);

  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state));

  p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !tx_req |=> !busy && !tx_grant);

endmodule

bind defer_ctrl defer_ctrl_chk #(
  .WATCH_BITS (WATCH_BITS),
  .BLIND_BITS (BLIND_BITS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bit_tick      (bit_tick),
  .tx_req        (tx_req),
  .carrier_sense (carrier_sense),
  .tx_done       (tx_done),
  .restart_defer (restart_defer),
  .busy          (busy),
  .tx_grant      (tx_grant),
  .state         (fsm_state),
  .pend          (req_pending)
);

// File: tb/tb_defer_ctrl.sv
module tb_defer_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WB = 60;
  localparam int BB = 36;
  localparam int GAP = WB + BB;

  logic clk, rst_n, bit_tick, tx_req, carrier_sense, tx_done, restart_defer;
  logic busy, tx_grant;

  defer_ctrl #(.WATCH_BITS(WB), .BLIND_BITS(BB)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_tick      (bit_tick),
    .tx_req        (tx_req),
    .carrier_sense (carrier_sense),
    .tx_done       (tx_done),
    .restart_defer (restart_defer),
    .busy          (busy),
    .tx_grant      (tx_grant)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  logic grant_prev = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: every grant rise must match the next expected cycle.
  int e_cyc;
  always @(negedge clk) begin
    if (rst_n && tx_grant && !grant_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected grant", cyc, -1);
      end else begin
        e_cyc = exp_q.pop_front();
        chk(cyc == e_cyc, "R3 grant rise cycle", cyc, e_cyc);
      end
    end
    grant_prev = tx_grant;
  end

  // Driver: issue ticks, pushing the expected grant cycle for the last one.
  task automatic ticks(input int n, input int gap, input bit push_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_tick = 1'b1;
      if (push_last && i == n - 1) exp_q.push_back(cyc + 1);
      @(negedge clk);
      bit_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic do_req();
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart_defer = 1'b1;
    @(negedge clk); restart_defer = 1'b0;
  endtask

  task automatic do_cs();
    @(negedge clk); carrier_sense = 1'b1;
    @(negedge clk); carrier_sense = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R3 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; tx_req = 1'b0; carrier_sense = 1'b0;
    tx_done = 1'b0; restart_defer = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(tx_grant == 1'b0, "R1 grant after reset", tx_grant, 0);
    rst_n = 1'b1;

    // R2 request raises busy
    do_req();
    chk(busy == 1'b1, "R2 busy on request", busy, 1);
    chk(tx_grant == 1'b0, "R2 no grant yet", tx_grant, 0);

    // R3 / R6 gap length, idle cycles without ticks do not count
    ticks(GAP - 1, 1, 1'b0);
    chk(tx_grant == 1'b0, "R3 one tick short", tx_grant, 0);
    repeat (10) @(negedge clk);
    chk(tx_grant == 1'b0, "R6 no tick no progress", tx_grant, 0);
    ticks(1, 0, 1'b1);
    chk(tx_grant == 1'b1, "R3 grant after full gap", tx_grant, 1);
    chk(busy == 1'b1, "R11 busy with grant", busy, 1);

    // R7 hold, then R9 release
    repeat (5) @(negedge clk);
    chk(tx_grant == 1'b1, "R7 grant held", tx_grant, 1);
    do_done();
    chk(tx_grant == 1'b0, "R7 grant drops on done", tx_grant, 0);
    chk(busy == 1'b0, "R9 busy drops on done", busy, 0);

    // R12 stray pulses while idle
    do_done();
    do_restart();
    ticks(5, 0, 1'b0);
    chk(busy == 1'b0, "R12 idle stays idle", busy, 0);
    chk(tx_grant == 1'b0, "R12 no grant while idle", tx_grant, 0);

    // R4 carrier in watched part restarts gap
    do_req();
    ticks(50, 1, 1'b0);
    do_cs();
    ticks(GAP - 1, 1, 1'b0);
    chk(tx_grant == 1'b0, "R4 gap restarted by carrier", tx_grant, 0);
    ticks(1, 1, 1'b1);
    chk(tx_grant == 1'b1, "R4 grant after restarted gap", tx_grant, 1);

    // R10 request in same cycle as done
    @(negedge clk); tx_done = 1'b1; tx_req = 1'b1;
    @(negedge clk); tx_done = 1'b0; tx_req = 1'b0;
    chk(busy == 1'b1, "R10 busy kept on same-cycle request", busy, 1);
    chk(tx_grant == 1'b0, "R10 grant ends on done", tx_grant, 0);

    // R5 carrier in blind part ignored
    ticks(WB, 1, 1'b0);
    carrier_sense = 1'b1;
    ticks(BB, 1, 1'b1);
    carrier_sense = 1'b0;
    chk(tx_grant == 1'b1, "R5 blind carrier ignored", tx_grant, 1);

    // R8 restart during grant
    do_restart();
    chk(tx_grant == 1'b0, "R8 grant drops on restart", tx_grant, 0);
    chk(busy == 1'b1, "R8 busy kept on restart", busy, 1);
    ticks(GAP, 1, 1'b1);
    chk(tx_grant == 1'b1, "R8 grant after fresh gap", tx_grant, 1);

    // R10 request during grant is remembered
    do_req();
    chk(tx_grant == 1'b1, "R10 request keeps grant", tx_grant, 1);
    repeat (3) @(negedge clk);
    do_done();
    chk(busy == 1'b1, "R10 busy kept by pending request", busy, 1);
    chk(tx_grant == 1'b0, "R10 grant ends", tx_grant, 0);
    ticks(GAP, 0, 1'b1);
    chk(tx_grant == 1'b1, "R10 grant for pending frame", tx_grant, 1);
    do_done();
    chk(busy == 1'b0, "R9 busy drops after last frame", busy, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected grants seen", exp_q.size(), 0);
    finish_run();
  end

endmodule